// File: doc/BRIEF.md
# Index Register Address Generator

This block produces one data memory address per cycle from a file of eight 32-bit pointer (index) registers and eight 32-bit step (modify) registers. Each request names an index register, a step source and an operation. The step source is a modify register, a full 32-bit immediate or a sign-extended 6-bit immediate. The operations are: output the sum without updating the index, output the index and then advance it, advance the index with no output, and add-then-reverse. When bit-reverse mode is on, the address that index register 0 puts out is mirrored bit for bit. The register itself is never mirrored.

Each half of the file has a primary bank and an alternate bank: registers 0-3 form the low half and 4-7 the high half. The two halves are switched by separate mode bits, so one half can be kept for a new context while the other half is shared. The bank switch lags the mode write by one cycle. Software loads any register through a write port and reads it back through a combinational read port. Both ports see the active bank.

Top module: `idx_addr_gen`

## Requirements
- R1: Operation code 0 (pre-modify) outputs index plus step and leaves the index register unchanged.
- R2: Operation code 1 (post-modify) outputs the unmodified index and writes index plus step back into the index register.
- R3: Operation code 2 (modify-only) writes index plus step back into the index register and raises no address strobe.
- R4: When the bit-reverse mode bit is 1, the 32-bit output address of index register 0 is bit-reversed for pre-modify and post-modify. The stored index is never reversed, and the other index registers are not affected. Example: index 0x8A000 with step 0x4000000 in post-modify outputs 0x51000 and leaves 0x408A000.
- R5: Operation code 3 (reverse-update) adds the full 32-bit immediate to any index register, reverses the 32-bit sum and writes it back. It does this whatever the bit-reverse mode setting, and it raises no address strobe.
- R6: Step source code 0 selects the modify register named by the request, code 1 selects the 32-bit immediate and code 2 selects immediate bits 5:0 sign-extended. Code 3 acts as code 1. All sums wrap modulo 2^32.
- R7: The low-half bank bit selects the alternate bank for registers 0-3 and the high-half bank bit does the same for registers 4-7. Reset selects the primary banks and clears every register. The inactive bank keeps its contents.
- R8: After a mode write, the cycle that follows still uses the old banks. The new banks apply from the second cycle on. The bit-reverse bit applies from the cycle after the write.
- R9: addr_o and addr_valid_o are registered. addr_valid_o is high for exactly the one cycle that follows each accepted pre-modify or post-modify request.
- R10: A load (write select 0 = index file, 1 = modify file) and an update to the same index register in the same cycle leave the loaded value. The read port shows the active-bank value of the selected register in the cycle after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | 0 pre-modify, 1 post-modify, 2 modify-only, 3 reverse-update |
| req_idx_i | input | 3 | Index register number |
| req_msrc_i | input | 2 | Step source: 0 modify register, 1 imm32, 2 imm6 |
| req_mreg_i | input | 3 | Modify register number |
| req_imm_i | input | 32 | Immediate step |
| mode_we_i | input | 1 | Write the mode bits |
| mode_brev_i | input | 1 | Bit-reverse mode for index register 0 |
| mode_alt_lo_i | input | 1 | Alternate bank for registers 0-3 |
| mode_alt_hi_i | input | 1 | Alternate bank for registers 4-7 |
| wr_en_i | input | 1 | Register load strobe |
| wr_sel_i | input | 1 | 0 index file, 1 modify file |
| wr_num_i | input | 3 | Register number to load |
| wr_data_i | input | 32 | Load data |
| rd_sel_i | input | 1 | Readback file select, 0 index, 1 modify |
| rd_num_i | input | 3 | Readback register number |
| rd_data_o | output | 32 | Readback data, active bank |
| addr_valid_o | output | 1 | Address strobe |
| addr_o | output | 32 | Generated address |

## Verification
The assertions check the output side on every cycle. The strobe follows only pre-modify and post-modify requests. A pre-modify address equals the index plus the step seen in the request cycle, and a post-modify address equals that index. The output of register 0 is the mirror image of its index whenever reverse mode is on. Write-back effects can only be seen through the bench's directed scenarios, which read the registers back after each one. These effects are: the index left unchanged by pre-modify, the add-then-reverse result, wrap at 2^32, bank retention, the one-cycle bank lag and the priority of a load over an update.

// File: rtl/idx_addr_pkg.sv
package idx_addr_pkg;
  typedef enum logic [1:0] {
    OP_PRE   = 2'd0,
    OP_POST  = 2'd1,
    OP_MOD   = 2'd2,
    OP_BRUPD = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    MS_MREG  = 2'd0,
    MS_IMM   = 2'd1,
    MS_SHORT = 2'd2,
    MS_RSVD  = 2'd3
  } msrc_e;
endpackage

// File: rtl/idx_addr_mode.sv
module idx_addr_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic brev_i,
  input  logic alt_lo_i,
  input  logic alt_hi_i,
  output logic brev_o,
  output logic mode_lo_o,
  output logic mode_hi_o,
  output logic bank_lo_o,
  output logic bank_hi_o
);
  logic brev_q, lo_q, hi_q, bank_lo_q, bank_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brev_q <= 1'b0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
    end else if (we_i) begin
      brev_q <= brev_i;
      lo_q   <= alt_lo_i;
      hi_q   <= alt_hi_i;
    end
  end

  // bank select trails the mode register by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_lo_q <= 1'b0;
      bank_hi_q <= 1'b0;
    end else begin
      bank_lo_q <= lo_q;
      bank_hi_q <= hi_q;
    end
  end

  assign brev_o    = brev_q;
  assign mode_lo_o = lo_q;
  assign mode_hi_o = hi_q;
  assign bank_lo_o = bank_lo_q;
  assign bank_hi_o = bank_hi_q;
endmodule

// File: rtl/idx_addr_bankfile.sv
module idx_addr_bankfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int NW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bank_lo_i,
  input  logic          bank_hi_i,
  input  logic          wa_en_i,
  input  logic [NW-1:0] wa_num_i,
  input  logic [DW-1:0] wa_data_i,
  input  logic          wb_en_i,
  input  logic [NW-1:0] wb_num_i,
  input  logic [DW-1:0] wb_data_i,
  input  logic [NW-1:0] ra_num_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [NW-1:0] rb_num_i,
  output logic [DW-1:0] rb_data_o
);
  localparam int HALF = NREG / 2;

  logic [DW-1:0] mem_q [2*NREG];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam bit IS_HI = (r >= HALF);
      logic act;
      logic hit_a, hit_b;
      assign act   = ((IS_HI ? bank_hi_i : bank_lo_i) == b[0]);
      assign hit_a = wa_en_i && (wa_num_i == r[NW-1:0]);
      assign hit_b = wb_en_i && (wb_num_i == r[NW-1:0]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          mem_q[b*NREG+r] <= '0;
        else if (act) begin
          if (hit_a)      mem_q[b*NREG+r] <= wa_data_i;
          else if (hit_b) mem_q[b*NREG+r] <= wb_data_i;
        end
      end
    end
  end

  function automatic logic [NW:0] phys(input logic [NW-1:0] n, input logic lo, input logic hi);
    logic bk;
    bk = n[NW-1] ? hi : lo;
    return {bk, n};
  endfunction

  assign ra_data_o = mem_q[phys(ra_num_i, bank_lo_i, bank_hi_i)];
  assign rb_data_o = mem_q[phys(rb_num_i, bank_lo_i, bank_hi_i)];
endmodule

// File: rtl/idx_addr_alu.sv
module idx_addr_alu
  import idx_addr_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SIMM_W   = 6,
  parameter int NW       = 3,
  parameter int BREV_REG = 0
) (
  input  op_e           op_i,
  input  msrc_e         msrc_i,
  input  logic [NW-1:0] idx_num_i,
  input  logic [AW-1:0] idx_val_i,
  input  logic [AW-1:0] mreg_val_i,
  input  logic [AW-1:0] imm_i,
  input  logic          brev_en_i,
  output logic          fire_o,
  output logic [AW-1:0] addr_o,
  output logic          upd_en_o,
  output logic [AW-1:0] upd_data_o,
  output logic [AW-1:0] mod_val_o
);
  localparam logic [NW-1:0] BREV_SEL = NW'(BREV_REG);

  logic [AW-1:0] mod_val, sum, brsum, raw, raw_rev, brsum_rev;

  always_comb begin
    unique case (msrc_i)
      MS_MREG:  mod_val = mreg_val_i;
      MS_SHORT: mod_val = {{(AW-SIMM_W){imm_i[SIMM_W-1]}}, imm_i[SIMM_W-1:0]};
      default:  mod_val = imm_i;
    endcase
  end

  assign sum   = idx_val_i + mod_val;
  assign brsum = idx_val_i + imm_i;
  assign raw   = (op_i == OP_PRE) ? sum : idx_val_i;

  for (genvar g = 0; g < AW; g++) begin : g_rev
    assign raw_rev[g]   = raw[AW-1-g];
    assign brsum_rev[g] = brsum[AW-1-g];
  end

  assign fire_o     = (op_i == OP_PRE) || (op_i == OP_POST);
  assign addr_o     = (brev_en_i && idx_num_i == BREV_SEL) ? raw_rev : raw;
  assign upd_en_o   = (op_i != OP_PRE);
  assign upd_data_o = (op_i == OP_BRUPD) ? brsum_rev : sum;
  assign mod_val_o  = mod_val;
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_addr_pkg::*;
#(
  parameter int AW       = 32,
  parameter int NREG     = 8,
  parameter int SIMM_W   = 6,
  parameter int BREV_REG = 0,
  localparam int NW      = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [NW-1:0] req_idx_i,
  input  logic [1:0]    req_msrc_i,
  input  logic [NW-1:0] req_mreg_i,
  input  logic [AW-1:0] req_imm_i,
  input  logic          mode_we_i,
  input  logic          mode_brev_i,
  input  logic          mode_alt_lo_i,
  input  logic          mode_alt_hi_i,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [NW-1:0] wr_num_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          rd_sel_i,
  input  logic [NW-1:0] rd_num_i,
  output logic [AW-1:0] rd_data_o,
  output logic          addr_valid_o,
  output logic [AW-1:0] addr_o
);
  logic brev_en, mode_lo, mode_hi, bank_lo, bank_hi;
  logic [AW-1:0] idx_val, mreg_val, idx_rb, mod_rb;
  logic fire, upd_en;
  logic [AW-1:0] gen_addr, upd_data, mod_val;
  logic addr_vld_q;
  logic [AW-1:0] addr_q;

  idx_addr_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (mode_we_i),
    .brev_i    (mode_brev_i),
    .alt_lo_i  (mode_alt_lo_i),
    .alt_hi_i  (mode_alt_hi_i),
    .brev_o    (brev_en),
    .mode_lo_o (mode_lo),
    .mode_hi_o (mode_hi),
    .bank_lo_o (bank_lo),
    .bank_hi_o (bank_hi)
  );

  idx_addr_bankfile #(.DW(AW), .NREG(NREG)) u_ifile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bank_lo_i (bank_lo),
    .bank_hi_i (bank_hi),
    .wa_en_i   (wr_en_i && !wr_sel_i),
    .wa_num_i  (wr_num_i),
    .wa_data_i (wr_data_i),
    .wb_en_i   (req_valid_i && upd_en),
    .wb_num_i  (req_idx_i),
    .wb_data_i (upd_data),
    .ra_num_i  (req_idx_i),
    .ra_data_o (idx_val),
    .rb_num_i  (rd_num_i),
    .rb_data_o (idx_rb)
  );

  idx_addr_bankfile #(.DW(AW), .NREG(NREG)) u_mfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bank_lo_i (bank_lo),
    .bank_hi_i (bank_hi),
    .wa_en_i   (wr_en_i && wr_sel_i),
    .wa_num_i  (wr_num_i),
    .wa_data_i (wr_data_i),
    .wb_en_i   (1'b0),
    .wb_num_i  ('0),
    .wb_data_i ('0),
    .ra_num_i  (req_mreg_i),
    .ra_data_o (mreg_val),
    .rb_num_i  (rd_num_i),
    .rb_data_o (mod_rb)
  );

  idx_addr_alu #(
    .AW(AW), .SIMM_W(SIMM_W), .NW(NW), .BREV_REG(BREV_REG)
  ) u_alu (
    .op_i       (op_e'(req_op_i)),
    .msrc_i     (msrc_e'(req_msrc_i)),
    .idx_num_i  (req_idx_i),
    .idx_val_i  (idx_val),
    .mreg_val_i (mreg_val),
    .imm_i      (req_imm_i),
    .brev_en_i  (brev_en),
    .fire_o     (fire),
    .addr_o     (gen_addr),
    .upd_en_o   (upd_en),
    .upd_data_o (upd_data),
    .mod_val_o  (mod_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_vld_q <= 1'b0;
      addr_q     <= '0;
    end else begin
      addr_vld_q <= req_valid_i && fire;
      if (req_valid_i && fire) addr_q <= gen_addr;
    end
  end

  assign addr_valid_o = addr_vld_q;
  assign addr_o       = addr_q;
  assign rd_data_o    = rd_sel_i ? mod_rb : idx_rb;
endmodule

// File: rtl/idx_addr_gen_chk.sv
module idx_addr_gen_chk #(
  parameter int AW = 32,
  parameter int NW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    req_op_i,
  input logic [NW-1:0] req_idx_i,
  input logic          brev_i,
  input logic [AW-1:0] idx_val_i,
  input logic [AW-1:0] mod_val_i,
  input logic          addr_valid_o,
  input logic [AW-1:0] addr_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic plain;
  assign plain = !(brev_i && req_idx_i == '0);

  p_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (addr_valid_o == $past(req_valid_i && (req_op_i == 2'd0 || req_op_i == 2'd1))));

  p_pre_out_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd0 && plain) |=> (addr_o == $past(idx_val_i + mod_val_i)));

  p_post_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd1 && plain) |=> (addr_o == $past(idx_val_i)));

  p_no_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd2) |=> !addr_valid_o);

  p_no_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd3) |=> !addr_valid_o);

  p_mirror_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd1 && !plain) |=> (addr_o == mirror($past(idx_val_i))));
endmodule

bind idx_addr_gen idx_addr_gen_chk #(.AW(AW), .NW(NW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .req_idx_i    (req_idx_i),
  .brev_i       (brev_en),
  .idx_val_i    (idx_val),
  .mod_val_i    (mod_val),
  .addr_valid_o (addr_valid_o),
  .addr_o       (addr_o)
);

// File: tb/idx_addr_gen_tb.sv
module idx_addr_gen_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 0;
  logic [1:0] req_op = 0, req_msrc = 0;
  logic [2:0] req_idx = 0, req_mreg = 0;
  logic [31:0] req_imm = 0;
  logic mode_we = 0, mode_brev = 0, mode_lo = 0, mode_hi = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [2:0] wr_num = 0;
  logic [31:0] wr_data = 0;
  logic rd_sel = 0;
  logic [2:0] rd_num = 0;
  logic [31:0] rd_data, addr;
  logic addr_valid;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  idx_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_idx_i(req_idx),
    .req_msrc_i(req_msrc), .req_mreg_i(req_mreg), .req_imm_i(req_imm),
    .mode_we_i(mode_we), .mode_brev_i(mode_brev),
    .mode_alt_lo_i(mode_lo), .mode_alt_hi_i(mode_hi),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_num_i(wr_num), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_num_i(rd_num), .rd_data_o(rd_data),
    .addr_valid_o(addr_valid), .addr_o(addr)
  );

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic load(input logic sel, input logic [2:0] num, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_num = num; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rb(input logic sel, input logic [2:0] num, output logic [31:0] d);
    rd_sel = sel; rd_num = num;
    #1;
    d = rd_data;
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] idx, input logic [1:0] ms,
                       input logic [2:0] mr, input logic [31:0] imm);
    req_valid = 1; req_op = op; req_idx = idx; req_msrc = ms; req_mreg = mr; req_imm = imm;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic set_mode(input logic br, input logic lo, input logic hi);
    mode_we = 1; mode_brev = br; mode_lo = lo; mode_hi = hi;
    @(negedge clk);
    mode_we = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R7 reset strobe", {31'd0, addr_valid}, 32'd0);
    check("R9 reset addr", addr, 32'd0);
    rb(0, 3, d); check("R7 reset index", d, 32'd0);
    rb(1, 6, d); check("R7 reset modify", d, 32'd0);
  endtask

  task automatic t_pre;
    logic [31:0] d;
    load(0, 2, 32'h100);
    load(1, 5, 32'h20);
    rb(1, 5, d); check("R10 modify load readback", d, 32'h20);
    issue(0, 2, 0, 5, 32'h0);
    check("R1 pre strobe", {31'd0, addr_valid}, 32'd1);
    check("R1 pre addr", addr, 32'h120);
    rb(0, 2, d); check("R1 index unchanged", d, 32'h100);
    @(negedge clk);
    check("R9 strobe one cycle", {31'd0, addr_valid}, 32'd0);
  endtask

  task automatic t_post;
    logic [31:0] d;
    issue(1, 2, 1, 0, 32'h10);
    check("R2 post addr", addr, 32'h100);
    check("R2 post strobe", {31'd0, addr_valid}, 32'd1);
    rb(0, 2, d); check("R2 index updated", d, 32'h110);
  endtask

  task automatic t_modonly;
    logic [31:0] d;
    issue(2, 2, 2, 0, 32'hFFFF_FF3E);
    check("R3 no strobe", {31'd0, addr_valid}, 32'd0);
    check("R3 addr held", addr, 32'h100);
    rb(0, 2, d); check("R6 imm6 sign-extended", d, 32'h10E);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    load(0, 4, 32'hFFFF_FFF0);
    issue(1, 4, 3, 0, 32'h20);
    check("R6 code3 as imm32 addr", addr, 32'hFFFF_FFF0);
    rb(0, 4, d); check("R6 wrap mod 2^32", d, 32'h10);
  endtask

  task automatic t_brev;
    logic [31:0] d;
    set_mode(1, 0, 0);
    load(0, 0, 32'h0008_A000);
    load(1, 0, 32'h0400_0000);
    issue(1, 0, 0, 0, 32'h0);
    check("R4 post reversed addr", addr, 32'h0005_1000);
    rb(0, 0, d); check("R4 stored not reversed", d, 32'h0408_A000);
    issue(0, 0, 1, 0, 32'h0);
    check("R4 pre reversed addr", addr, rev32(32'h0408_A000));
    load(0, 1, 32'h0008_A000);
    issue(0, 1, 1, 0, 32'h0);
    check("R4 other index plain", addr, 32'h0008_A000);
  endtask

  task automatic t_brupd;
    logic [31:0] d;
    load(0, 3, 32'h4);
    issue(3, 3, 0, 0, 32'h4);
    check("R5 no strobe", {31'd0, addr_valid}, 32'd0);
    rb(0, 3, d); check("R5 reversed sum, mode on", d, 32'h1000_0000);
    set_mode(0, 0, 0);
    load(0, 7, 32'h1);
    issue(3, 7, 2, 0, 32'h1);
    rb(0, 7, d); check("R5 reversed sum, mode off", d, 32'h4000_0000);
  endtask

  task automatic t_banks;
    logic [31:0] d;
    load(0, 5, 32'h5555);
    set_mode(0, 1, 0);
    rb(0, 2, d); check("R8 old bank in lag cycle", d, 32'h10E);
    @(negedge clk);
    rb(0, 2, d); check("R7 alternate bank empty", d, 32'h0);
    rb(0, 5, d); check("R7 high half untouched", d, 32'h5555);
    load(0, 2, 32'h77);
    issue(1, 2, 1, 0, 32'h1);
    check("R7 alternate bank addr", addr, 32'h77);
    set_mode(0, 0, 0);
    @(negedge clk);
    rb(0, 2, d); check("R7 primary retained", d, 32'h10E);
    set_mode(0, 1, 0);
    @(negedge clk);
    rb(0, 2, d); check("R7 alternate retained", d, 32'h78);
    set_mode(0, 0, 0);
    @(negedge clk);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    load(0, 6, 32'h40);
    req_valid = 1; req_op = 1; req_idx = 6; req_msrc = 1; req_imm = 32'h8;
    wr_en = 1; wr_sel = 0; wr_num = 6; wr_data = 32'h777;
    @(negedge clk);
    req_valid = 0; wr_en = 0;
    check("R10 collision addr", addr, 32'h40);
    rb(0, 6, d); check("R10 load wins", d, 32'h777);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_pre();
    t_post();
    t_modonly();
    t_wrap();
    t_brev();
    t_brupd();
    t_banks();
    t_collide();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule